// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block sits between the byte deserializer of a 10 Mbps receive path and the receive buffer. It decides for each incoming frame whether the frame is kept. The decision covers several conditions: whether carrier has been present long enough, whether reception is enabled, whether the frame is the port's own half-duplex transmission, and whether the destination address passes the unicast, broadcast, multicast-hash, accept-all-multicast and promiscuous rules. Accepted frames leave as a byte stream. The four trailing check bytes can optionally be removed. A frame that runs past the length limit is cut off and flagged.

The first six bytes of a frame are held in a six-stage byte pipe until the address decision is known, so a rejected frame never reaches the output. After the decision the pipe keeps a constant six-byte delay. When the end marker arrives, the pipe drains its tail one byte per cycle, or only two bytes when the check bytes are stripped. Frames are expected to be separated by at least eight idle input cycles so that the drain finishes before the next frame starts.

The controller has five states. IDLE waits for a start byte. HDR collects the address. PASS streams the frame. DRAIN empties the pipe. DROP skips to the end marker. The transitions are:
- IDLE→HDR when a start byte is admitted.
- IDLE→DROP when a start byte is not admitted.
- HDR→PASS when the address is a hit.
- HDR→DRAIN when the address is a hit on a frame of exactly six bytes.
- HDR→DROP or HDR→IDLE when the address is a miss or the frame is a runt.
- PASS→DRAIN on the end marker.
- PASS→DROP or PASS→IDLE when the frame is aborted.
- DRAIN→IDLE on the last byte.
- DROP→IDLE on the end marker.

Top module: `rx_frame_filter`

## Requirements
- R1: While reset is held, out_valid, out_last, accept_pulse, reject_pulse, abort_pulse and abort_sticky are all 0.
- R2: With crs_filter_en set, a start byte is admitted only after crs has been high for 12 bit_tick strobes. Without enough strobes the whole frame is ignored: no output and no strobe. With crs_filter_en clear, a start byte is admitted whenever crs is high.
- R3: rx_enable is sampled only on the start byte. A frame that starts while it is 0 is ignored. Clearing it in the middle of a frame has no effect on that frame.
- R4: The first destination byte is the byte on in_data with in_sof, and station_addr[7:0] matches it (byte k matches bits 8k+7:8k). A unicast frame is one whose first destination byte has bit 0 clear. A unicast frame equal to station_addr is passed. Any other unicast frame produces reject_pulse in the cycle of its sixth byte and no output.
- R5: A destination of all ones is always passed.
- R6: A frame whose first destination byte has bit 0 set is a multicast frame. With accept_all_mcast set, every multicast frame is passed. Otherwise a multicast frame is passed only if mcast_hash[idx] is 1. idx is bits 31:26 of a CRC-32 register computed as follows: the register starts at all ones; it takes the 48 destination bits byte by byte, bit 0 of each byte first; on each bit it shifts right and, when the old bit 0 XOR the data bit is 1, it is XORed with 0xEDB88320.
- R7: With promisc set, every admitted frame is passed, whatever its destination.
- R8: With full_duplex clear and tx_active high on the start byte, the frame is ignored even in promiscuous mode. With full_duplex set, tx_active has no effect.
- R9: A passed frame leaves in order on out_data, with byte k appearing as the input byte k+6 arrives and the last bytes drained on consecutive cycles after the end marker. With strip_crc set, the last 4 bytes are withheld. out_last and accept_pulse are high together on the final output byte only.
- R10: A frame of 1532 bytes is passed in full. When byte 1533 arrives, abort_pulse is high in that cycle, no further bytes are output and no accept_pulse follows.
- R11: abort_sticky goes to 1 in the cycle after abort_pulse and stays there until a cycle with abort_clr high. If abort_clr and abort_pulse fall in the same cycle, the set wins.
- R12: An admitted frame shorter than 6 bytes produces reject_pulse on its end-marker byte and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crs | input | 1 | Carrier sense |
| bit_tick | input | 1 | One strobe per bit time |
| crs_filter_en | input | 1 | Require 12 bit times of carrier before a frame |
| rx_enable | input | 1 | Receive enable, sampled at frame start |
| strip_crc | input | 1 | Withhold the last 4 bytes |
| accept_all_mcast | input | 1 | Pass every multicast frame |
| promisc | input | 1 | Pass every frame |
| full_duplex | input | 1 | Full-duplex operation |
| tx_active | input | 1 | Own transmitter busy |
| station_addr | input | 48 | Station address, first byte in bits 7:0 |
| mcast_hash | input | 64 | Multicast hash table |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_data | input | 8 | Input byte |
| abort_clr | input | 1 | Software clear of the abort status |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final output byte of a frame |
| accept_pulse | output | 1 | Frame passed (with last byte) |
| reject_pulse | output | 1 | Frame refused by address or runt |
| abort_pulse | output | 1 | Frame cut off for length |
| abort_sticky | output | 1 | Sticky abort status |

## Verification
The length abort and the software clear of the sticky status can land in the same clock cycle. The bench provokes this by raising abort_clr exactly on the 1533rd byte of a second overlong frame, after a lone clear has already dropped the flag. Its reference model applies set-over-clear and compares abort_sticky on every cycle, so a design that lets the clear win shows a mismatch in the following cycle. A second overlap is a receive-enable drop in the middle of a frame that is still streaming; it is judged by the full byte count arriving.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int DA_BYTES = 6;
    localparam logic [31:0] HASH_POLY = 32'hEDB88320;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_PASS,
        S_DRAIN,
        S_DROP
    } rxf_state_e;

    // Bits 31:26 of the reflected CRC-32 register after the 48 address bits.
    function automatic logic [5:0] hash_index(input logic [8*DA_BYTES-1:0] da);
        logic [31:0] crc;
        crc = '1;
        for (int i = 0; i < 8 * DA_BYTES; i++) begin
            if (crc[0] ^ da[i]) crc = (crc >> 1) ^ HASH_POLY;
            else                crc = crc >> 1;
        end
        return crc[31:26];
    endfunction

endpackage

// File: rtl/rxf_carrier_qual.sv
module rxf_carrier_qual #(
    parameter int QUAL_TICKS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic crs,
    input  logic bit_tick,
    input  logic filt_en,
    output logic qualified
);
    localparam int CW = $clog2(QUAL_TICKS + 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                                   run_cnt <= '0;
        else if (!crs)                                run_cnt <= '0;
        else if (bit_tick && run_cnt != CW'(QUAL_TICKS)) run_cnt <= run_cnt + 1'b1;
    end

    assign qualified = crs && (!filt_en || run_cnt == CW'(QUAL_TICKS));

    // R2: a carrier gap restarts the qualification window
    p_gap_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !crs |=> run_cnt == '0);
    // R2: the window counter saturates at the threshold
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CW'(QUAL_TICKS));
endmodule

// File: rtl/rxf_dest_match.sv
module rxf_dest_match import rxf_pkg::*; (
    input  logic [8*DA_BYTES-1:0] da,
    input  logic [8*DA_BYTES-1:0] station,
    input  logic [63:0]           hash_tbl,
    input  logic                  promisc,
    input  logic                  all_mcast,
    output logic                  hit
);
    logic is_mcast, is_bcast, is_self, hash_hit;

    always_comb begin
        is_mcast = da[0];
        is_bcast = &da;
        is_self  = (da == station);
        hash_hit = hash_tbl[hash_index(da)];
        hit = promisc || is_bcast
           || (!is_mcast && is_self)
           || (is_mcast && (all_mcast || hash_hit));
    end
endmodule

// File: rtl/rxf_byte_pipe.sv
module rxf_byte_pipe #(
    parameter int DEPTH = 6,
    parameter int W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift,
    input  logic [W-1:0]       din,
    output logic [DEPTH*W-1:0] stages
);
    logic [W-1:0] st [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n)     st[g] <= '0;
                else if (shift) st[g] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n)     st[g] <= '0;
                else if (shift) st[g] <= st[g-1];
            end
        end
        assign stages[g*W +: W] = st[g];
    end
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter import rxf_pkg::*; #(
    parameter int CRC_BYTES  = 4,
    parameter int MAX_LEN    = 1532,
    parameter int QUAL_TICKS = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  crs,
    input  logic                  bit_tick,
    input  logic                  crs_filter_en,
    input  logic                  rx_enable,
    input  logic                  strip_crc,
    input  logic                  accept_all_mcast,
    input  logic                  promisc,
    input  logic                  full_duplex,
    input  logic                  tx_active,
    input  logic [8*DA_BYTES-1:0] station_addr,
    input  logic [63:0]           mcast_hash,
    input  logic                  in_valid,
    input  logic                  in_sof,
    input  logic                  in_eof,
    input  logic [7:0]            in_data,
    input  logic                  abort_clr,
    output logic                  out_valid,
    output logic [7:0]            out_data,
    output logic                  out_last,
    output logic                  accept_pulse,
    output logic                  reject_pulse,
    output logic                  abort_pulse,
    output logic                  abort_sticky
);
    localparam int CW          = $clog2(MAX_LEN + 2);
    localparam int DW          = $clog2(DA_BYTES + 1);
    localparam int DRAIN_STRIP = DA_BYTES - CRC_BYTES;

    rxf_state_e          state, state_nx;
    logic [CW-1:0]       cnt, cnt_nx;
    logic [DW-1:0]       drain, drain_nx;
    logic                shift;
    logic                carrier_ok, start_ok, addr_hit;
    logic [8*DA_BYTES-1:0] pipe_bus, da_now;
    logic [DW-1:0]       drain_load;

    rxf_carrier_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
        .clk(clk), .rst_n(rst_n), .crs(crs), .bit_tick(bit_tick),
        .filt_en(crs_filter_en), .qualified(carrier_ok)
    );

    rxf_byte_pipe #(.DEPTH(DA_BYTES), .W(8)) u_pipe (
        .clk(clk), .rst_n(rst_n), .shift(shift), .din(in_data), .stages(pipe_bus)
    );

    // Destination as it stands when the last address byte is on the input.
    always_comb begin
        for (int k = 0; k < DA_BYTES - 1; k++)
            da_now[8*k +: 8] = pipe_bus[8*(DA_BYTES-2-k) +: 8];
        da_now[8*(DA_BYTES-1) +: 8] = in_data;
    end

    rxf_dest_match u_match (
        .da(da_now), .station(station_addr), .hash_tbl(mcast_hash),
        .promisc(promisc), .all_mcast(accept_all_mcast), .hit(addr_hit)
    );

    assign start_ok   = rx_enable && carrier_ok && (full_duplex || !tx_active);
    assign drain_load = strip_crc ? DW'(DRAIN_STRIP) : DW'(DA_BYTES);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= S_IDLE;
            cnt          <= '0;
            drain        <= '0;
            abort_sticky <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            drain <= drain_nx;
            if (abort_pulse)    abort_sticky <= 1'b1;
            else if (abort_clr) abort_sticky <= 1'b0;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx     = state;
        cnt_nx       = cnt;
        drain_nx     = drain;
        shift        = 1'b0;
        out_valid    = 1'b0;
        out_data     = pipe_bus[8*(DA_BYTES-1) +: 8];
        out_last     = 1'b0;
        accept_pulse = 1'b0;
        reject_pulse = 1'b0;
        abort_pulse  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (in_valid && in_sof) begin
                    if (!start_ok) begin
                        state_nx = in_eof ? S_IDLE : S_DROP;
                    end else if (in_eof) begin
                        reject_pulse = 1'b1;
                    end else begin
                        shift    = 1'b1;
                        cnt_nx   = CW'(1);
                        state_nx = S_HDR;
                    end
                end
            end
            S_HDR: begin
                if (in_valid) begin
                    shift  = 1'b1;
                    cnt_nx = cnt + 1'b1;
                    if (cnt == CW'(DA_BYTES - 1)) begin
                        if (addr_hit) begin
                            if (in_eof) begin
                                state_nx = S_DRAIN;
                                drain_nx = drain_load;
                            end else begin
                                state_nx = S_PASS;
                            end
                        end else begin
                            reject_pulse = 1'b1;
                            state_nx     = in_eof ? S_IDLE : S_DROP;
                        end
                    end else if (in_eof) begin
                        reject_pulse = 1'b1;
                        state_nx     = S_IDLE;
                    end
                end
            end
            S_PASS: begin
                if (in_valid) begin
                    if (cnt == CW'(MAX_LEN)) begin
                        abort_pulse = 1'b1;
                        state_nx    = in_eof ? S_IDLE : S_DROP;
                    end else begin
                        shift     = 1'b1;
                        out_valid = 1'b1;
                        cnt_nx    = cnt + 1'b1;
                        if (in_eof) begin
                            state_nx = S_DRAIN;
                            drain_nx = drain_load;
                        end
                    end
                end
            end
            S_DRAIN: begin
                shift     = 1'b1;
                out_valid = 1'b1;
                drain_nx  = drain - 1'b1;
                if (drain == DW'(1)) begin
                    out_last     = 1'b1;
                    accept_pulse = 1'b1;
                    state_nx     = S_IDLE;
                end
            end
            S_DROP: begin
                if (in_valid && in_eof) state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // R10: at most one frame verdict per cycle
    p_one_verdict_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({accept_pulse, reject_pulse, abort_pulse}));
    // R10: the length counter never passes the limit
    p_len_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAX_LEN));
    // R11: an abort sets the status in the next cycle
    p_sticky_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> abort_sticky);
    // R11: the status holds until cleared
    p_sticky_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_sticky && !abort_clr) |=> abort_sticky);
    // R11: a clear without a concurrent abort drops the status
    p_sticky_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_clr && !abort_pulse) |=> !abort_sticky);
    // R9: the drain emits on consecutive cycles
    p_drain_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DRAIN && !out_last) |=> out_valid);
    // R9: after the final byte the block is idle
    p_last_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> state == S_IDLE);
endmodule

// File: tb/test_rx_frame_filter.sv
module test_rx_frame_filter;
    typedef byte unsigned bq_t[$];
    localparam int MAXL = 1532;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, crs, bit_tick, crs_filter_en, rx_enable, strip_crc;
    logic        accept_all_mcast, promisc, full_duplex, tx_active;
    logic [47:0] station_addr;
    logic [63:0] mcast_hash;
    logic        in_valid, in_sof, in_eof, abort_clr;
    logic [7:0]  in_data;
    logic        out_valid, out_last, accept_pulse, reject_pulse, abort_pulse, abort_sticky;
    logic [7:0]  out_data;

    rx_frame_filter i_rx_frame_filter (
        .clk(clk), .rst_n(rst_n), .crs(crs), .bit_tick(bit_tick),
        .crs_filter_en(crs_filter_en), .rx_enable(rx_enable), .strip_crc(strip_crc),
        .accept_all_mcast(accept_all_mcast), .promisc(promisc),
        .full_duplex(full_duplex), .tx_active(tx_active),
        .station_addr(station_addr), .mcast_hash(mcast_hash),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .abort_clr(abort_clr), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .accept_pulse(accept_pulse), .reject_pulse(reject_pulse),
        .abort_pulse(abort_pulse), .abort_sticky(abort_sticky)
    );

    int n_checks = 0, n_errs = 0, delivered = 0;
    bit done = 0, mon_on = 0, exp_rej = 0, exp_abt = 0, m_sticky = 0, m_carrier = 0;
    byte unsigned exp_q[$];
    bit exp_lq[$];
    byte unsigned mon_e;
    bit mon_l;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] hidx(input bq_t f);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int b = 0; b < 6; b++)
            for (int k = 0; k < 8; k++) begin
                bit fb = c[0] ^ f[b][k];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        return c[31:26];
    endfunction

    function automatic bit m_accept(input bq_t f);
        bit all1 = 1, self = 1;
        for (int b = 0; b < 6; b++) begin
            if (f[b] != 8'hFF) all1 = 0;
            if (f[b] != station_addr[8*b +: 8]) self = 0;
        end
        if (promisc || all1) return 1;
        if (!f[0][0]) return self;
        if (accept_all_mcast) return 1;
        return mcast_hash[hidx(f)];
    endfunction

    function automatic bq_t mk(input logic [47:0] da, input int n, input int seed);
        bq_t f;
        for (int i = 0; i < n; i++)
            f.push_back(i < 6 ? da[8*i +: 8] : 8'((i * 7 + seed) & 255));
        return f;
    endfunction

    // Cycle-by-cycle comparison against the reference queues and flags
    always @(negedge clk) if (mon_on) begin
        if (out_valid) begin
            delivered++;
            if (exp_q.size() == 0) chk(0, "R9", "unexpected byte", out_data, 0);
            else begin
                mon_e = exp_q.pop_front();
                mon_l = exp_lq.pop_front();
                chk(out_data == mon_e, "R9", "out_data", out_data, mon_e);
                chk(out_last == mon_l, "R9", "out_last", out_last, mon_l);
                chk(accept_pulse == mon_l, "R9", "accept_pulse", accept_pulse, mon_l);
            end
        end else begin
            chk(!out_last && !accept_pulse, "R9", "idle last/accept",
                {out_last, accept_pulse}, 0);
        end
        chk(reject_pulse == exp_rej, "R4 R12", "reject_pulse", reject_pulse, exp_rej);
        chk(abort_pulse == exp_abt, "R10", "abort_pulse", abort_pulse, exp_abt);
        chk(abort_sticky == m_sticky, "R11", "abort_sticky", abort_sticky, m_sticky);
        m_sticky = exp_abt ? 1'b1 : (abort_clr ? 1'b0 : m_sticky);
    end

    task automatic carrier_up(input int k);
        @(posedge clk); #1; crs = 0; bit_tick = 0;
        @(posedge clk); #1; crs = 1;
        for (int t = 0; t < k; t++) begin
            bit_tick = 1; @(posedge clk); #1;
        end
        bit_tick = 0;
        m_carrier = !crs_filter_en || k >= 12;
    endtask

    task automatic send_frame(input string tag, input bq_t f, input int ticks,
                              input int drop_en_at, input bit clr_on_abort);
        int n = f.size(), rej_at = -1, abt_at = -1, out_n = 0;
        bit start_ok;
        carrier_up(ticks);
        start_ok = rx_enable && m_carrier && (full_duplex || !tx_active);
        if (start_ok) begin
            if (n < 6) rej_at = n - 1;
            else if (!m_accept(f)) rej_at = 5;
            else if (n > MAXL) begin
                abt_at = MAXL;
                out_n = MAXL - 6;
                for (int j = 0; j < out_n; j++) begin exp_q.push_back(f[j]); exp_lq.push_back(0); end
            end else begin
                out_n = strip_crc ? n - 4 : n;
                for (int j = 0; j < out_n; j++) begin
                    exp_q.push_back(f[j]); exp_lq.push_back(j == out_n - 1);
                end
            end
        end
        delivered = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1; in_data = f[i]; in_sof = (i == 0); in_eof = (i == n - 1);
            exp_rej = (i == rej_at); exp_abt = (i == abt_at);
            abort_clr = clr_on_abort && (i == abt_at);
            if (i == drop_en_at) rx_enable = 0;
        end
        @(posedge clk); #1;
        in_valid = 0; in_sof = 0; in_eof = 0; exp_rej = 0; exp_abt = 0; abort_clr = 0;
        repeat (10) @(posedge clk);
        #1;
        chk(delivered == out_n, tag, "delivered byte count", delivered, out_n);
        chk(exp_q.size() == 0, tag, "missing bytes", exp_q.size(), 0);
        crs = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        logic [47:0] self_da = 48'h5A4B_3C2D_1E10;
        logic [47:0] mc_da   = 48'h0300_5E00_0001;
        rst_n = 0; crs = 0; bit_tick = 0; crs_filter_en = 0; rx_enable = 0;
        strip_crc = 0; accept_all_mcast = 0; promisc = 0; full_duplex = 1;
        tx_active = 0; station_addr = self_da; mcast_hash = '0;
        in_valid = 0; in_sof = 0; in_eof = 0; in_data = 0; abort_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_valid && !out_last, "R1", "reset out", {out_valid, out_last}, 0);
        chk(!accept_pulse && !reject_pulse && !abort_pulse, "R1", "reset strobes",
            {accept_pulse, reject_pulse, abort_pulse}, 0);
        chk(!abort_sticky, "R1", "reset sticky", abort_sticky, 0);
        @(posedge clk); #1; rst_n = 1; rx_enable = 1; mon_on = 1;

        send_frame("R4", mk(self_da, 20, 1), 0, -1, 0);
        strip_crc = 1;
        send_frame("R9", mk(self_da, 20, 2), 0, -1, 0);
        send_frame("R9", mk(self_da, 6, 3), 0, -1, 0);
        strip_crc = 0;
        send_frame("R4", mk(48'h5A4B_3C2D_1E12, 20, 4), 0, -1, 0);
        send_frame("R5", mk(48'hFFFF_FFFF_FFFF, 16, 5), 0, -1, 0);
        accept_all_mcast = 1;
        send_frame("R6", mk(mc_da, 16, 6), 0, -1, 0);
        accept_all_mcast = 0;
        send_frame("R6", mk(mc_da, 16, 7), 0, -1, 0);
        mcast_hash = 64'd1 << hidx(mk(mc_da, 6, 0));
        send_frame("R6", mk(mc_da, 16, 8), 0, -1, 0);
        mcast_hash = '0;
        promisc = 1;
        send_frame("R7", mk(48'h0102_0304_0500, 18, 9), 0, -1, 0);
        full_duplex = 0; tx_active = 1;
        send_frame("R8", mk(self_da, 18, 10), 0, -1, 0);
        full_duplex = 1;
        send_frame("R8", mk(self_da, 18, 11), 0, -1, 0);
        tx_active = 0; promisc = 0;
        rx_enable = 0;
        send_frame("R3", mk(self_da, 18, 12), 0, -1, 0);
        rx_enable = 1;
        send_frame("R3", mk(self_da, 30, 13), 0, 10, 0);
        rx_enable = 1;
        crs_filter_en = 1;
        send_frame("R2", mk(self_da, 18, 14), 5, -1, 0);
        send_frame("R2", mk(self_da, 18, 15), 12, -1, 0);
        crs_filter_en = 0;
        send_frame("R12", mk(self_da, 4, 16), 0, -1, 0);
        send_frame("R10", mk(self_da, MAXL, 17), 0, -1, 0);
        send_frame("R10", mk(self_da, MAXL + 1, 18), 0, -1, 0);
        @(posedge clk); #1; abort_clr = 1;
        @(posedge clk); #1; abort_clr = 0;
        repeat (2) @(posedge clk);
        send_frame("R11", mk(self_da, MAXL + 1, 19), 0, -1, 1);
        repeat (3) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule